// File: doc/BRIEF.md
# Shared-Buffer General Purpose Register Pair

This block provides two 32-bit general purpose registers that have no storage of their own. They borrow the two holding buffers of a compare register whose value must cross from a fast host bus clock into a slow counter clock. The write buffer sends the compare value to the counter domain through a toggle handshake. The read buffer receives the value that came back. A pair-enable bit in a control register picks the owner of the buffers. When it is 0 they serve the compare register. When it is 1 the even register uses the write buffer and the odd register uses the read buffer.

The odd register lives in the read buffer, and every completed transfer reloads that buffer. Software therefore writes the even register first, waits until its busy flag drops, and only then writes the odd register. The odd register's busy flag mirrors the even one for as long as a transfer is pending. Writes to a busy register are dropped without an error. The control register cannot change while any transfer is pending.

Top module: `shared_gp_regs`

## Requirements
- R1: After reset, the buffers, the pair-enable bit, all busy flags, the read data and `cmp_value` are 0.
- R2: Register addresses are: 0 = compare, 1 = even GP register, 2 = odd GP register, 3 = control (bit 0 is the pair enable), 4 = status (bit 0 compare busy, bit 1 even busy, bit 2 odd busy). Other read bits and addresses return 0, and `rdata` is 0 when `rd_en` is low.
- R3: An accepted compare write (pair enable 0), or an accepted even-register write (pair enable 1), loads the write buffer. It raises the matching busy flag from the cycle after the write. The value appears on `cmp_value` in the counter domain, and the flag clears once the acknowledge has returned through the synchronizer.
- R4: While an even-register transfer is pending, the odd register's busy flag also reads 1 and the compare busy flag reads 0.
- R5: An accepted odd-register write stores the data directly in the read buffer, with no busy flag. A later even-register transfer overwrites the read buffer with the transferred value on completion.
- R6: A write to a register whose busy flag is set is ignored. The buffers keep their contents.
- R7: A control register write is ignored while any transfer is pending.
- R8: With pair enable 0, writes to the GP registers are ignored and they read 0. With pair enable 1, compare writes are ignored and the compare register reads 0.
- R9: An even-register transfer replaces `cmp_value`. After the pair enable is cleared, a new compare write sets `cmp_value` again.
- R10: A compare read returns the read buffer. It shows the previous value until the pending transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| cnt_clk | input | 1 | Slow counter-domain clock |
| cnt_rst_n | input | 1 | Counter-domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| busy | output | 3 | Busy flags {odd GP, even GP, compare} |
| cmp_value | output | 32 | Compare value held in the counter domain |

## Verification
The assertions check on every cycle that no transfer is launched while another is pending. They also check that an accepted write raises exactly the right busy pattern one cycle later, that the write buffer and pair enable hold still while a transfer is pending, and that a completed transfer loads the read buffer and the counter-domain value. Only the bench's scenarios show the buffer aliasing as software sees it. These scenarios cover a late even-register write clobbering the odd register, a compare read showing the old value before completion, and the compare value being lost after GP use and restored by a rewrite. They also cover the dropped writes and the read-back of each register under both pair-enable settings.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
   localparam int ADDR_W = 3;
   localparam int BUSY_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_CMP    = 3'd0,
      A_GP_LO  = 3'd1,
      A_GP_HI  = 3'd2,
      A_CTRL   = 3'd3,
      A_STAT   = 3'd4
   } reg_addr_e;

   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_CMP  = 2'd1,
      OWN_GP   = 2'd2
   } owner_e;
endpackage

// File: rtl/sgp_sync.sv
module sgp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sgp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sgp_xfer.sv
module sgp_xfer #(
   parameter int DATA_W = 32,
   parameter int STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              launch,
   input  logic [DATA_W-1:0] launch_data,
   output logic              pending,
   output logic              done,
   input  logic              cnt_clk,
   input  logic              cnt_rst_n,
   output logic [DATA_W-1:0] cnt_value
);
   logic req_tgl, req_s, req_seen, load;
   logic ack_tgl, ack_s, ack_seen;

   // bus side: request toggle and pending flag
   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         req_tgl  <= 1'b0;
         pending  <= 1'b0;
         ack_seen <= 1'b0;
      end else begin
         ack_seen <= ack_s;
         if (launch) begin
            req_tgl <= ~req_tgl;
            pending <= 1'b1;
         end else if (done) begin
            pending <= 1'b0;
         end
      end
   end

   assign done = ack_s ^ ack_seen;

   sgp_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(cnt_clk), .rst_n(cnt_rst_n), .d(req_tgl), .q(req_s)
   );

   // counter side: capture the held data, echo the toggle
   assign load = req_s ^ req_seen;

   always_ff @(posedge cnt_clk or negedge cnt_rst_n) begin
      if (!cnt_rst_n) begin
         req_seen  <= 1'b0;
         ack_tgl   <= 1'b0;
         cnt_value <= '0;
      end else begin
         req_seen <= req_s;
         if (load) begin
            cnt_value <= launch_data;
            ack_tgl   <= ~ack_tgl;
         end
      end
   end

   sgp_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_s)
   );

   // R6: one transfer at a time through the shared buffer
   assert_no_overlap_R6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      launch |-> !pending);

   // R3: the counter domain takes exactly the held write-buffer value
   assert_cnt_load_R3: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n || !bus_rst_n)
      load |=> cnt_value == $past(launch_data));
endmodule

// File: rtl/sgp_regs.sv
module sgp_regs
   import sgp_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [BUSY_W-1:0] busy,
   output logic              launch,
   output logic [DATA_W-1:0] wbuf,
   input  logic              pending,
   input  logic              done,
   input  logic [DATA_W-1:0] cnt_value
);
   if (DATA_W < BUSY_W) begin : g_bad_width
      $error("sgp_regs: DATA_W too small for status field");
   end

   logic [DATA_W-1:0] rbuf;
   logic              gp_en;
   owner_e            owner;
   logic              busy_cmp, busy_gp;
   logic              wr_cmp_ok, wr_gp0_ok, wr_gp1_ok, wr_ctrl_ok;
   logic [DATA_W-1:0] rd_mux;

   assign busy_cmp = pending && (owner == OWN_CMP);
   assign busy_gp  = pending && (owner == OWN_GP);
   assign busy     = {busy_gp, busy_gp, busy_cmp};

   // write acceptance: one shared channel, so any pending transfer blocks
   assign wr_cmp_ok  = wr_en && (addr == A_CMP)   && !gp_en && !pending;
   assign wr_gp0_ok  = wr_en && (addr == A_GP_LO) &&  gp_en && !pending;
   assign wr_gp1_ok  = wr_en && (addr == A_GP_HI) &&  gp_en && !busy_gp;
   assign wr_ctrl_ok = wr_en && (addr == A_CTRL)  && !pending;
   assign launch     = wr_cmp_ok || wr_gp0_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbuf  <= '0;
         rbuf  <= '0;
         gp_en <= 1'b0;
         owner <= OWN_NONE;
      end else begin
         if (launch) begin
            wbuf  <= wdata;
            owner <= wr_gp0_ok ? OWN_GP : OWN_CMP;
         end
         if (done)           rbuf <= cnt_value;
         else if (wr_gp1_ok) rbuf <= wdata;
         if (wr_ctrl_ok)     gp_en <= wdata[0];
      end
   end

   always_comb begin
      rd_mux = '0;
      unique case (addr)
         A_CMP:   rd_mux = gp_en ? '0 : rbuf;
         A_GP_LO: rd_mux = gp_en ? wbuf : '0;
         A_GP_HI: rd_mux = gp_en ? rbuf : '0;
         A_CTRL:  rd_mux[0] = gp_en;
         A_STAT:  rd_mux[BUSY_W-1:0] = busy;
         default: rd_mux = '0;
      endcase
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= rd_en ? rd_mux : '0;
      end
   end else begin : g_rd_comb
      assign rdata = rd_en ? rd_mux : '0;
   end

   // R3: accepted compare write shows only the compare busy flag
   assert_cmp_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmp_ok |=> busy == 3'b001);

   // R4: accepted even write marks both GP flags busy
   assert_gp_pair_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_gp0_ok |=> busy == 3'b110);

   // R6: write buffer frozen while its transfer is in flight
   assert_wbuf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pending |=> $stable(wbuf));

   // R7: pair enable cannot move while a transfer is pending
   assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pending |=> $stable(gp_en));

   // R5: completion reloads the read buffer from the counter domain
   assert_rbuf_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rbuf == $past(cnt_value));
endmodule

// File: rtl/shared_gp_regs.sv
module shared_gp_regs
   import sgp_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit READ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_clk,
   input  logic              cnt_rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [BUSY_W-1:0] busy,
   output logic [DATA_W-1:0] cmp_value
);
   logic              launch, pending, done;
   logic [DATA_W-1:0] wbuf;

   sgp_regs #(.DATA_W(DATA_W), .READ_REG(READ_REG)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .busy(busy),
      .launch(launch), .wbuf(wbuf),
      .pending(pending), .done(done), .cnt_value(cmp_value)
   );

   sgp_xfer #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_xfer (
      .bus_clk(clk), .bus_rst_n(rst_n),
      .launch(launch), .launch_data(wbuf),
      .pending(pending), .done(done),
      .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n),
      .cnt_value(cmp_value)
   );

   // R4: busy flags never show both owners at once
   assert_one_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy[1], busy[0]}) && (busy[2] == busy[1]));
endmodule

// File: tb/tb_shared_gp_regs.sv
module tb_shared_gp_regs;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_PERIOD = 50;
   localparam int NVEC = 20;
   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IDLE = 2'd2;

   // {op, addr, data, expected, requirement}
   localparam logic [72:0] VEC [NVEC] = '{
      {OP_WR,   3'd0, 32'h1111_0000, 32'h0,          4'd3},
      {OP_RD,   3'd0, 32'h0,         32'h0,          4'd10},
      {OP_IDLE, 3'd0, 32'h0,         32'h0,          4'd3},
      {OP_RD,   3'd0, 32'h0,         32'h1111_0000,  4'd3},
      {OP_WR,   3'd3, 32'h1,         32'h0,          4'd2},
      {OP_RD,   3'd3, 32'h0,         32'h1,          4'd2},
      {OP_WR,   3'd1, 32'hA5A5_A5A5, 32'h0,          4'd3},
      {OP_IDLE, 3'd0, 32'h0,         32'h0,          4'd3},
      {OP_WR,   3'd2, 32'h5A5A_5A5A, 32'h0,          4'd5},
      {OP_RD,   3'd1, 32'h0,         32'hA5A5_A5A5,  4'd2},
      {OP_RD,   3'd2, 32'h0,         32'h5A5A_5A5A,  4'd5},
      {OP_RD,   3'd0, 32'h0,         32'h0,          4'd8},
      {OP_WR,   3'd1, 32'h00C0_FFEE, 32'h0,          4'd5},
      {OP_IDLE, 3'd0, 32'h0,         32'h0,          4'd5},
      {OP_RD,   3'd2, 32'h0,         32'h00C0_FFEE,  4'd5},
      {OP_WR,   3'd3, 32'h0,         32'h0,          4'd9},
      {OP_RD,   3'd1, 32'h0,         32'h0,          4'd8},
      {OP_WR,   3'd0, 32'h0BAD_F00D, 32'h0,          4'd9},
      {OP_IDLE, 3'd0, 32'h0,         32'h0,          4'd9},
      {OP_RD,   3'd0, 32'h0,         32'h0BAD_F00D,  4'd9}
   };

   logic        clk = 1'b0, cnt_clk = 1'b0;
   logic        rst_n = 1'b0, cnt_rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, cmp_value;
   logic [2:0]  busy;
   int          n_checks = 0, n_fail = 0;
   bit          finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always #(CNT_PERIOD/2) cnt_clk = ~cnt_clk;

   shared_gp_regs dut (
      .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .busy(busy), .cmp_value(cmp_value)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      @(negedge clk);
      while (busy != 3'b000 && n < 400) begin
         @(negedge clk);
         n++;
      end
      check(req, {29'b0, busy}, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      #(CLK_PERIOD * 3 + 2);
      cnt_rst_n = 1'b1;
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      check("R1 busy", {29'b0, busy}, 32'h0);
      check("R1 cmp_value", cmp_value, 32'h0);
      for (int a = 0; a < 5; a++) begin
         bus_rd(a[2:0], v);
         check("R1 read", v, 32'h0);
      end

      // vector walk
      for (int i = 0; i < NVEC; i++) begin
         logic [1:0]  op;
         logic [2:0]  va;
         logic [31:0] vd, ve;
         logic [3:0]  vr;
         {op, va, vd, ve, vr} = VEC[i];
         case (op)
            OP_WR:   bus_wr(va, vd);
            OP_RD:   begin
                        bus_rd(va, v);
                        check($sformatf("R%0d vec%0d", vr, i), v, ve);
                     end
            default: wait_idle($sformatf("R%0d vec%0d idle", vr, i));
         endcase
      end
      check("R9 cmp_value restored", cmp_value, 32'h0BAD_F00D);

      // R8: GP write with pair enable 0 is dropped
      bus_wr(3'd1, 32'h77);
      check("R8 no busy", {29'b0, busy}, 32'h0);
      repeat (20) @(negedge clk);
      check("R8 cmp_value", cmp_value, 32'h0BAD_F00D);

      // R3 / R7 / R6 / R10 with a compare transfer in flight
      bus_wr(3'd0, 32'h22);
      check("R3 cmp busy", {29'b0, busy}, 32'h1);
      bus_rd(3'd0, v);
      check("R10 old value", v, 32'h0BAD_F00D);
      bus_wr(3'd3, 32'h1);
      bus_rd(3'd3, v);
      check("R7 ctrl ignored", v, 32'h0);
      bus_wr(3'd0, 32'h33);
      wait_idle("R3 clears");
      bus_rd(3'd0, v);
      check("R6 cmp kept", v, 32'h22);
      check("R3 cmp_value", cmp_value, 32'h22);

      // R4 / R6 / R9 with an even GP transfer in flight
      bus_wr(3'd3, 32'h1);
      bus_wr(3'd1, 32'h44);
      check("R4 pair busy", {29'b0, busy}, 32'h6);
      bus_rd(3'd4, v);
      check("R2 status", v, 32'h6);
      bus_wr(3'd1, 32'h55);
      wait_idle("R4 clears");
      bus_rd(3'd1, v);
      check("R6 gp0 kept", v, 32'h44);
      check("R9 cmp overwritten", cmp_value, 32'h44);
      bus_wr(3'd0, 32'h66);
      check("R8 cmp write dropped", {29'b0, busy}, 32'h0);
      repeat (20) @(negedge clk);
      check("R8 cmp_value kept", cmp_value, 32'h44);

      finish_run();
   end
endmodule